// File: doc/BRIEF.md
# Shared-Line Interrupt Input Conditioner

This block sits in front of the request register of an eight-input interrupt controller. It does not sample a single wire per input. Each input keeps a count of how many sources are currently driving it. Sources report their changes as events: raise, drop, or a one-shot pulse. From each event and the input's trigger mode, the block works out whether the request bit for that input must be set or cleared. It then sends one-cycle set and clear strobes to the priority resolver that owns the request register.

Each input is either edge- or level-sensitive, as chosen by a readable and writable trigger-mode register. A fixed per-instance mask (parameter) decides which bits of that register can be written at all. The inputs outside the mask therefore stay edge-sensitive whatever software writes. Raising an input whose count is full, or dropping one whose count is empty, does not change the count. Either case produces a one-cycle error flag and advances a wrapping event counter. Events are ignored until the controller reports that its initialization is complete.

Top module: `irq_pin_cond`

## Requirements
- R1: An accepted raise event (`ev_kind` = 0) adds one to the addressed input's count. If the count is already all ones, it stays there, `sat_hi_err` pulses and `sat_hi_cnt` advances by one.
- R2: An accepted drop event (`ev_kind` = 1) takes one from the count. If the count is already zero, it stays there, `sat_lo_err` pulses and `sat_lo_cnt` advances by one.
- R3: A raise that moves a count from zero to one strobes the input's `irr_set` bit in either trigger mode.
- R4: In level mode (trigger-mode bit = 1), any raise or drop that leaves the count nonzero strobes `irr_set`. This includes a raise refused at saturation.
- R5: A drop that moves a count from one to zero strobes `irr_clr` only in level mode. In edge mode no strobe is issued and the request stays pending.
- R6: A pulse event (`ev_kind` = 2) acts as a raise followed by a drop, leaving the count unchanged. The drop is skipped when the raise saturates. In level mode a pulse on an empty input gives net `irr_clr`. In edge mode it gives `irr_set`.
- R7: A trigger-mode write stores `tm_wr_data` AND `TM_WR_MASK` (default 0xF8, so inputs 0–2 stay edge; a second instance would use 0xDE). The stored value appears on `tm_rd_data` the next cycle. An event in the same cycle as a write uses the old mode.
- R8: While `ctrl_ready` is low, events change no count and produce no strobe, error or counter change.
- R9: Every output reflects an event one clock after it is presented. Strobes and errors last one cycle, at most one input strobes per cycle, and `ev_kind` = 3 is a no-op. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_ready | input | 1 | Controller initialized; events ignored while low |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_pin | input | 3 | Input index addressed by the event |
| ev_kind | input | 2 | 0 raise, 1 drop, 2 pulse, 3 no-op |
| tm_wr_en | input | 1 | Write the trigger-mode register |
| tm_wr_data | input | 8 | Trigger-mode write value, bit i = 1 selects level mode |
| tm_rd_data | output | 8 | Current trigger-mode register |
| irr_set | output | 8 | One-cycle request-set strobes, one bit per input |
| irr_clr | output | 8 | One-cycle request-clear strobes, one bit per input |
| sat_hi_err | output | 1 | Raise refused at full count |
| sat_lo_err | output | 1 | Drop refused at empty count |
| sat_hi_cnt | output | 16 | Wrapping count of refused raises |
| sat_lo_cnt | output | 16 | Wrapping count of refused drops |

## Verification
A count that drifts is not visible the moment it goes wrong. It shows up at the next event on that input: a missing or extra strobe on a zero crossing, or a saturation error flagged too early or too late. The bench therefore drives every input through both zero crossings and through the full-count boundary in both modes. A stale trigger-mode bit shows as a strobe in the wrong mode on the next level-mode crossing. A reference model compares all outputs on every cycle, so a fault is reported in the cycle right after the event that exposes it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    EV_RAISE = 2'd0,
    EV_DROP  = 2'd1,
    EV_PULSE = 2'd2,
    EV_NOP   = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irqc_trig_mode.sv
module irqc_trig_mode #(
  parameter int                   NUM_PINS   = 8,
  parameter logic [NUM_PINS-1:0] TM_WR_MASK = 8'hF8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] mode_q
);
  logic [NUM_PINS-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_data & TM_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  // R7: a write lands masked on the next cycle
  p_tm_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == ($past(wr_data) & TM_WR_MASK)));
  // R7: no write, no change
  p_tm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/irqc_pin_counter.sv
module irqc_pin_counter
  import irqc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit,
  input  ev_kind_e kind,
  input  logic     level,
  output logic     set_d,
  output logic     clr_d,
  output logic     hi_d,
  output logic     lo_d
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max, at_zero, at_one;

  assign at_max  = (cnt_q == CNT_MAX);
  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == CNT_ONE);

  always_comb begin
    cnt_d = cnt_q;
    set_d = 1'b0;
    clr_d = 1'b0;
    hi_d  = 1'b0;
    lo_d  = 1'b0;
    if (hit) begin
      unique case (kind)
        EV_RAISE: begin
          if (at_max) begin
            hi_d  = 1'b1;
            set_d = level;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
            set_d = at_zero | level;
          end
        end
        EV_DROP: begin
          if (at_zero) begin
            lo_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
            set_d = level & ~at_one;
            clr_d = level & at_one;
          end
        end
        EV_PULSE: begin
          if (at_max) begin
            hi_d  = 1'b1;
            set_d = level;
          end else if (at_zero) begin
            set_d = ~level;
            clr_d = level;
          end else begin
            set_d = level;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: an unsaturated raise adds exactly one
  p_cnt_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == EV_RAISE && !at_max) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
  // R1: a saturated count never wraps
  p_cnt_hold_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind != EV_DROP && kind != EV_NOP && at_max) |=> (cnt_q == CNT_MAX));
  // R2: an empty count never wraps
  p_cnt_hold_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == EV_DROP && at_zero) |=> (cnt_q == '0));
  // R6: a pulse leaves the count where it was
  p_pulse_net_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == EV_PULSE) |=> $stable(cnt_q));
  // R8: without an accepted event the count holds
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cnt_q));
endmodule

// File: rtl/irqc_sat_stats.sv
module irqc_sat_stats #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_any,
  input  logic              lo_any,
  output logic              hi_err_q,
  output logic              lo_err_q,
  output logic [STAT_W-1:0] hi_cnt_q,
  output logic [STAT_W-1:0] lo_cnt_q
);
  localparam logic [STAT_W-1:0] STEP = STAT_W'(1);

  logic [STAT_W-1:0] hi_cnt_d, lo_cnt_d;

  always_comb begin
    hi_cnt_d = hi_cnt_q;
    lo_cnt_d = lo_cnt_q;
    if (hi_any) hi_cnt_d = hi_cnt_q + STEP;
    if (lo_any) lo_cnt_d = lo_cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_err_q <= 1'b0;
      lo_err_q <= 1'b0;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else begin
      hi_err_q <= hi_any;
      lo_err_q <= lo_any;
      hi_cnt_q <= hi_cnt_d;
      lo_cnt_q <= lo_cnt_d;
    end
  end

  // R1: the high counter moves exactly with the high flag
  p_hi_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_err_q |-> (hi_cnt_q == $past(hi_cnt_q) + STEP));
  // R2: the low counter moves exactly with the low flag
  p_lo_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_err_q |-> $stable(lo_cnt_q));
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
  import irqc_pkg::*;
#(
  parameter int                   NUM_PINS   = 8,
  parameter int                   CNT_W      = 8,
  parameter int                   STAT_W     = 16,
  parameter logic [NUM_PINS-1:0] TM_WR_MASK = 8'hF8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctrl_ready,
  input  logic                        ev_valid,
  input  logic [$clog2(NUM_PINS)-1:0] ev_pin,
  input  logic [1:0]                  ev_kind,
  input  logic                        tm_wr_en,
  input  logic [NUM_PINS-1:0]         tm_wr_data,
  output logic [NUM_PINS-1:0]         tm_rd_data,
  output logic [NUM_PINS-1:0]         irr_set,
  output logic [NUM_PINS-1:0]         irr_clr,
  output logic                        sat_hi_err,
  output logic                        sat_lo_err,
  output logic [STAT_W-1:0]           sat_hi_cnt,
  output logic [STAT_W-1:0]           sat_lo_cnt
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0] hit_vec, set_vec, clr_vec, hi_vec, lo_vec;
  logic [NUM_PINS-1:0] irr_set_q, irr_clr_q;
  ev_kind_e            kind;
  logic                accept;

  irqc_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  irqc_trig_mode #(
    .NUM_PINS   (NUM_PINS),
    .TM_WR_MASK (TM_WR_MASK)
  ) u_trig_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tm_wr_en),
    .wr_data (tm_wr_data),
    .mode_q  (mode_q)
  );

  assign kind   = ev_kind_e'(ev_kind);
  assign accept = ev_valid & ctrl_ready & (kind != EV_NOP);

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    assign hit_vec[gi] = accept & (ev_pin == PIN_W'(gi));

    irqc_pin_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .hit   (hit_vec[gi]),
      .kind  (kind),
      .level (mode_q[gi]),
      .set_d (set_vec[gi]),
      .clr_d (clr_vec[gi]),
      .hi_d  (hi_vec[gi]),
      .lo_d  (lo_vec[gi])
    );
  end

  irqc_sat_stats #(
    .STAT_W (STAT_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hi_any   (|hi_vec),
    .lo_any   (|lo_vec),
    .hi_err_q (sat_hi_err),
    .lo_err_q (sat_lo_err),
    .hi_cnt_q (sat_hi_cnt),
    .lo_cnt_q (sat_lo_cnt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irr_set_q <= '0;
      irr_clr_q <= '0;
    end else begin
      irr_set_q <= set_vec;
      irr_clr_q <= clr_vec;
    end
  end

  assign irr_set    = irr_set_q;
  assign irr_clr    = irr_clr_q;
  assign tm_rd_data = mode_q;

  // R8: nothing leaves the block for an event seen before initialization
  p_ignore_unready_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_ready |=> (irr_set == '0 && irr_clr == '0 && !sat_hi_err && !sat_lo_err));
  // R9: at most one input strobes per cycle
  p_single_input_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(irr_set | irr_clr));
  // R9: a no-op kind produces nothing
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_kind == 2'd3) |=> (irr_set == '0 && irr_clr == '0 && !sat_hi_err && !sat_lo_err));
  // R7: locked inputs never read back as level
  p_locked_edge_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tm_rd_data & ~TM_WR_MASK) == '0);
endmodule

// File: tb/irq_pin_cond_tb.sv
`timescale 1ns/1ps
module irq_pin_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_ready;
  logic       ev_valid;
  logic [2:0] ev_pin;
  logic [1:0] ev_kind;
  logic       tm_wr_en;
  logic [7:0] tm_wr_data;
  logic [7:0] tm_rd_data, irr_set, irr_clr;
  logic       sat_hi_err, sat_lo_err;
  logic [15:0] sat_hi_cnt, sat_lo_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  int m_cnt[8];
  int m_tm, m_hi_cnt, m_lo_cnt;
  int e_set, e_clr, e_hi, e_lo;

  always #2 clk = ~clk;

  irq_pin_cond u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_ready(ctrl_ready), .ev_valid(ev_valid),
    .ev_pin(ev_pin), .ev_kind(ev_kind), .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data),
    .tm_rd_data(tm_rd_data), .irr_set(irr_set), .irr_clr(irr_clr),
    .sat_hi_err(sat_hi_err), .sat_lo_err(sat_lo_err),
    .sat_hi_cnt(sat_hi_cnt), .sat_lo_cnt(sat_lo_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural model of one accepted clock
  task automatic model_step();
    int c, lv;
    e_set = 0; e_clr = 0; e_hi = 0; e_lo = 0;
    if (ev_valid && ctrl_ready && ev_kind != 2'd3) begin
      c  = m_cnt[ev_pin];
      lv = (m_tm >> ev_pin) & 1;
      if (ev_kind == 2'd0) begin
        if (c == 255) begin e_hi = 1; if (lv) e_set = 1; end
        else begin m_cnt[ev_pin] = c + 1; if (c == 0 || lv) e_set = 1; end
      end else if (ev_kind == 2'd1) begin
        if (c == 0) e_lo = 1;
        else begin
          m_cnt[ev_pin] = c - 1;
          if (lv && c > 1) e_set = 1;
          if (lv && c == 1) e_clr = 1;
        end
      end else begin
        if (c == 255) begin e_hi = 1; if (lv) e_set = 1; end
        else if (c == 0) begin if (lv) e_clr = 1; else e_set = 1; end
        else if (lv) e_set = 1;
      end
      if (e_set) e_set = 1 << ev_pin;
      if (e_clr) e_clr = 1 << ev_pin;
    end
    if (tm_wr_en) m_tm = tm_wr_data & 8'hF8;
    m_hi_cnt = (m_hi_cnt + e_hi) % 65536;
    m_lo_cnt = (m_lo_cnt + e_lo) % 65536;
  endtask

  task automatic compare(input string req);
    chk(irr_set == 8'(e_set), req, "irr_set", irr_set, e_set);
    chk(irr_clr == 8'(e_clr), req, "irr_clr", irr_clr, e_clr);
    chk(sat_hi_err == e_hi[0], req, "sat_hi_err", sat_hi_err, e_hi);
    chk(sat_lo_err == e_lo[0], req, "sat_lo_err", sat_lo_err, e_lo);
    chk(sat_hi_cnt == 16'(m_hi_cnt), req, "sat_hi_cnt", sat_hi_cnt, m_hi_cnt);
    chk(sat_lo_cnt == 16'(m_lo_cnt), req, "sat_lo_cnt", sat_lo_cnt, m_lo_cnt);
    chk(tm_rd_data == 8'(m_tm), req, "tm_rd_data", tm_rd_data, m_tm);
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
    ev_valid = 1'b0;
    tm_wr_en = 1'b0;
  endtask

  task automatic ev(input int kind, input int pin, input string req);
    ev_valid = 1'b1;
    ev_kind  = 2'(kind);
    ev_pin   = 3'(pin);
    tick(req);
  endtask

  task automatic tm_write(input int val, input string req);
    tm_wr_en   = 1'b1;
    tm_wr_data = 8'(val);
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    m_tm = 0; m_hi_cnt = 0; m_lo_cnt = 0;
    e_set = 0; e_clr = 0; e_hi = 0; e_lo = 0;
    rst_n = 1'b0; ctrl_ready = 1'b0; ev_valid = 1'b0; ev_pin = '0; ev_kind = '0;
    tm_wr_en = 1'b0; tm_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R9 reset");

    // R8: events before initialization
    ev(0, 3, "R8 raise while unready");
    ev(2, 3, "R8 pulse while unready");
    ev(0, 3, "R8 raise while unready");
    ctrl_ready = 1'b1;
    ev(1, 3, "R8 count untouched, drop refused (R2)");

    // R3 / R5 edge mode
    ev(0, 4, "R3 edge zero to one");
    ev(0, 4, "R3 no strobe at two");
    ev(1, 4, "R5 edge drop");
    ev(1, 4, "R5 edge one to zero no clear");
    ev(1, 4, "R2 empty drop");
    ev(3, 4, "R9 no-op kind");

    // R7 mask
    tm_write(8'hFF, "R7 write all ones");
    tm_write(8'h0F, "R7 write low nibble");
    tm_write(8'h88, "R7 level on 3 and 7");
    // R7 same-cycle write uses old mode
    ev_valid = 1'b1; ev_kind = 2'd0; ev_pin = 3'd6;
    tm_wr_en = 1'b1; tm_wr_data = 8'hC8;
    tick("R7 event with concurrent write");
    ev(1, 6, "R5 level one to zero");

    // R4 / R5 level mode
    ev(0, 3, "R4 level raise");
    ev(0, 3, "R4 level raise nonzero");
    ev(1, 3, "R4 level drop still nonzero");
    ev(1, 3, "R5 level one to zero");

    // R6 pulses
    ev(2, 5, "R6 edge pulse empty");
    ev(2, 3, "R6 level pulse empty");
    ev(0, 3, "R4 level raise");
    ev(2, 3, "R6 level pulse nonzero");
    ev(0, 5, "R6 edge count unchanged by pulse");
    ev(2, 5, "R6 edge pulse nonzero");
    ev(1, 5, "R5 edge back to zero");
    ev(1, 3, "R5 level back to zero");

    // R1 saturation, edge input 4 and level input 7
    for (int k = 0; k < 255; k++) ev(0, 4, "R1 fill edge");
    ev(0, 4, "R1 edge saturated raise");
    ev(2, 4, "R6 pulse at saturation skips drop");
    ev(1, 4, "R1 drop from full");
    ev(0, 4, "R1 refill");
    for (int k = 0; k < 255; k++) ev(0, 7, "R1 fill level");
    ev(0, 7, "R4 saturated level raise sets");
    ev(2, 7, "R6 level pulse at saturation");
    ev(1, 7, "R4 level drop from full");

    // R9 idle after activity
    tick("R9 idle");
    tick("R9 idle");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule